// File: doc/BRIEF.md
# Multi-Drop Serial Receiver with Standby Wakeup

This block receives asynchronous serial characters of 8 or 9 data bits, least significant bit first, framed by one start bit and one stop bit. A free-running tick at sixteen times the bit rate paces it. Each bit is settled by a two-of-three vote over the middle samples of the bit. A received character goes into a data register, sets a full flag and, when the stop bit reads low, a framing-error flag. A read strobe clears both flags.

On a multi-drop bus, a station that is not being addressed can put its receiver into standby. While in standby, characters are dropped and the receive interrupt is held low. A select bit chooses how standby ends. In idle mode it ends when the line has stayed high for one full character time after a stop bit. In address mode it ends when a character arrives whose top data bit is 1, and that character is kept. In both cases the hardware clears the standby bit on its own.

A single write strobe loads all control fields together. The receiver-enable field in that write only takes effect if the module enable was already set before the write.

Top module: `uart_wake_rx`

## Requirements
- R1: After reset, module enable, receiver enable, standby, full, framing error and interrupt are all 0.
- R2: A write leaves the receiver-enable bit unchanged when the module enable held before that write is 0.
- R3: In 8-bit mode (nine-bit select 0), a frame of start 0, eight data bits LSB first and stop 1 loads data_o[7:0] with data_o[8]=0 and sets full_o.
- R4: In 9-bit mode (nine-bit select 1), nine data bits are received LSB first into data_o[8:0].
- R5: Each bit is the majority of sub-bit samples 7, 8 and 9 of 0..15, counted from the tick that first sees the start edge, so a single-sample glitch at sample 8 does not change a bit, not even the start bit.
- R6: A stop bit read as 0 still loads the character and sets both full_o and frame_err_o.
- R7: A pulse on data_rd_i clears full_o and frame_err_o.
- R8: While the receiver enable is 0, no character is taken in, and full_o, frame_err_o and data_o keep their values.
- R9: While standby is set, irq_o is 0 even with flags set. Otherwise irq_o is full_o OR frame_err_o.
- R10: With wake select 0 (idle), characters arriving in standby are dropped. Standby clears itself once the line has been high for 10 (8-bit) or 11 (9-bit) bit times after a stop bit.
- R11: With wake select 1 (address), a standby character whose top data bit (bit 7 in 8-bit mode, bit 8 in 9-bit mode) is 0 is dropped. A character whose top data bit is 1 clears standby, is loaded and sets full_o. An idle line does not end standby in this mode.
- R12: A start bit whose vote comes out 1 returns the receiver to waiting, and nothing is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling tick, 16 per bit time |
| rxd_i | input | 1 | Serial line, idle high |
| cfg_we_i | input | 1 | Strobe that loads all control fields |
| cfg_mod_en_i | input | 1 | Module enable value to write |
| cfg_rx_en_i | input | 1 | Receiver enable value to write |
| cfg_rwu_i | input | 1 | Standby value to write |
| cfg_wake_sel_i | input | 1 | Wake method: 0 idle line, 1 address mark |
| cfg_nine_i | input | 1 | Data length: 0 eight bits, 1 nine bits |
| data_rd_i | input | 1 | Read strobe, clears the flags |
| data_o | output | 9 | Received character |
| full_o | output | 1 | Character waiting |
| frame_err_o | output | 1 | Last loaded character had a low stop bit |
| irq_o | output | 1 | Receive interrupt |
| mod_en_o | output | 1 | Module enable state |
| rx_en_o | output | 1 | Receiver enable state |
| rwu_o | output | 1 | Standby state |

## Verification
The assertions assume a few things about the inputs. tick_i pulses at a steady rate of no more than one per two clocks. rxd_i changes at most once per tick period, so the two-stage synchronizer passes each level on before the next tick. A control write never lands in the same cycle as a hardware wake, and a read strobe never coincides with a load. The stimulus keeps to these rules as follows. It derives the tick from a fixed divide-by-four counter. It changes the line only half a clock after a tick edge. It issues writes and reads only while the line has been idle long enough, or the receiver is mid-frame, so that no wake or load can be in progress.

// File: rtl/uart_wake_pkg.sv
package uart_wake_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/uart_wake_frame.sv
module uart_wake_frame
  import uart_wake_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          rxd_i,
  input  logic          en_i,
  input  logic          nine_i,
  output logic          line_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] data_o,
  output logic          stop_ok_o
);
  localparam int CW   = $clog2(OVS);
  localparam int IW   = $clog2(DW);
  localparam int SMID = OVS / 2;

  rx_state_e     state_q;
  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic [1:0]    votes_q;
  logic [IW-1:0] idx_q;
  logic [DW-1:0] data_q;
  logic          done_q, stop_ok_q;
  logic          line, in_win, bit_v, bit_end;
  logic [IW-1:0] last_idx;

  assign line     = sync_q[1];
  assign in_win   = (cnt_q >= CW'(SMID - 1)) && (cnt_q <= CW'(SMID + 1));
  assign bit_v    = votes_q[1];  // two or three ones
  assign bit_end  = (cnt_q == CW'(OVS - 1));
  assign last_idx = nine_i ? IW'(DW - 1) : IW'(DW - 2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rxd_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= RX_IDLE;
      cnt_q     <= '0;
      votes_q   <= '0;
      idx_q     <= '0;
      data_q    <= '0;
      done_q    <= 1'b0;
      stop_ok_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!en_i) begin
        state_q <= RX_IDLE;
      end else if (tick_i) begin
        if (state_q == RX_IDLE) begin
          if (!line) begin
            state_q <= RX_START;
            cnt_q   <= CW'(1);  // detection tick is sample 0
            votes_q <= '0;
            idx_q   <= '0;
            data_q  <= '0;
          end
        end else begin
          if (in_win && line) votes_q <= votes_q + 2'd1;
          if (bit_end) begin
            cnt_q   <= '0;
            votes_q <= '0;
            case (state_q)
              RX_START: state_q <= bit_v ? RX_IDLE : RX_DATA;
              RX_DATA: begin
                data_q[idx_q] <= bit_v;
                if (idx_q == last_idx) state_q <= RX_STOP;
                else                   idx_q   <= idx_q + IW'(1);
              end
              default: begin
                done_q    <= 1'b1;
                stop_ok_q <= bit_v;
                state_q   <= RX_IDLE;
              end
            endcase
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
      end
    end
  end

  assign line_o    = line;
  assign busy_o    = (state_q != RX_IDLE);
  assign done_o    = done_q;
  assign data_o    = data_q;
  assign stop_ok_o = stop_ok_q;

  assert_off_halts_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> state_q == RX_IDLE);
  assert_done_ends_frame_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_false_start_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_START && tick_i && bit_end && bit_v && en_i) |=> state_q == RX_IDLE);
endmodule

// File: rtl/uart_wake_idle.sv
module uart_wake_idle #(
  parameter int OVS = 16,
  parameter int DW  = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic line_i,
  input  logic busy_i,
  input  logic done_i,
  input  logic nine_i,
  output logic idle_o
);
  localparam int LIM8 = (DW + 1) * OVS;
  localparam int LIM9 = (DW + 2) * OVS;
  localparam int CW   = $clog2(LIM9);

  logic [CW-1:0] cnt_q;
  logic          armed_q, idle_q;
  logic [CW-1:0] lim;

  assign lim = nine_i ? CW'(LIM9 - 1) : CW'(LIM8 - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      idle_q  <= 1'b0;
    end else begin
      idle_q <= 1'b0;
      if (done_i) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
      end else if (!line_i || busy_i) begin
        cnt_q <= '0;
      end else if (tick_i && armed_q) begin
        if (cnt_q == lim) begin
          idle_q  <= 1'b1;
          armed_q <= 1'b0;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  assign idle_o = idle_q;

  assert_idle_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |=> !idle_o);
  assert_idle_not_in_frame_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !idle_o);
endmodule

// File: rtl/uart_wake_ctrl.sv
module uart_wake_ctrl #(
  parameter int DW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          w_mod_en_i,
  input  logic          w_rx_en_i,
  input  logic          w_rwu_i,
  input  logic          w_wake_sel_i,
  input  logic          w_nine_i,
  input  logic          rd_i,
  input  logic          done_i,
  input  logic [DW-1:0] frame_i,
  input  logic          stop_ok_i,
  input  logic          idle_i,
  output logic [DW-1:0] data_o,
  output logic          full_o,
  output logic          ferr_o,
  output logic          irq_o,
  output logic          mod_en_o,
  output logic          rx_en_o,
  output logic          rwu_o,
  output logic          wake_sel_o,
  output logic          nine_o
);
  logic          mod_en_q, rx_en_q, rwu_q, wake_sel_q, nine_q;
  logic          full_q, ferr_q;
  logic [DW-1:0] data_q;
  logic          addr_hit, wake_hit, load;

  assign addr_hit = nine_q ? frame_i[DW-1] : frame_i[DW-2];
  assign wake_hit = (!wake_sel_q && idle_i) || (wake_sel_q && done_i && addr_hit);
  assign load     = done_i && (!rwu_q || (wake_sel_q && addr_hit));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mod_en_q   <= 1'b0;
      rx_en_q    <= 1'b0;
      rwu_q      <= 1'b0;
      wake_sel_q <= 1'b0;
      nine_q     <= 1'b0;
      full_q     <= 1'b0;
      ferr_q     <= 1'b0;
      data_q     <= '0;
    end else begin
      if (we_i) begin
        mod_en_q   <= w_mod_en_i;
        wake_sel_q <= w_wake_sel_i;
        nine_q     <= w_nine_i;
        rwu_q      <= w_rwu_i;
        if (mod_en_q) rx_en_q <= w_rx_en_i;
      end else if (rwu_q && wake_hit) begin
        rwu_q <= 1'b0;
      end
      if (load) begin
        data_q <= frame_i;
        full_q <= 1'b1;
        ferr_q <= !stop_ok_i;
      end else if (rd_i) begin
        full_q <= 1'b0;
        ferr_q <= 1'b0;
      end
    end
  end

  assign data_o     = data_q;
  assign full_o     = full_q;
  assign ferr_o     = ferr_q;
  assign irq_o      = !rwu_q && (full_q || ferr_q);
  assign mod_en_o   = mod_en_q;
  assign rx_en_o    = rx_en_q;
  assign rwu_o      = rwu_q;
  assign wake_sel_o = wake_sel_q;
  assign nine_o     = nine_q;

  assert_rx_en_locked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mod_en_q |=> rx_en_q == $past(rx_en_q));
  assert_ferr_with_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ferr_q |-> full_q);
  // R11 as well: an address wake is one of the two legal sources
  assert_wake_source_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rwu_q) && !$past(we_i)) |->
      ($past(idle_i && !wake_sel_q) || $past(done_i && wake_sel_q && addr_hit)));
  assert_standby_no_load_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_q) |-> (!$past(rwu_q) || $past(wake_sel_q && addr_hit)));
endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx #(
  parameter int OVS = 16,
  parameter int DW  = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          rxd_i,
  input  logic          cfg_we_i,
  input  logic          cfg_mod_en_i,
  input  logic          cfg_rx_en_i,
  input  logic          cfg_rwu_i,
  input  logic          cfg_wake_sel_i,
  input  logic          cfg_nine_i,
  input  logic          data_rd_i,
  output logic [DW-1:0] data_o,
  output logic          full_o,
  output logic          frame_err_o,
  output logic          irq_o,
  output logic          mod_en_o,
  output logic          rx_en_o,
  output logic          rwu_o
);
  logic          line, busy, done, stop_ok, idle, wake_sel, nine, rx_en;
  logic [DW-1:0] frame;

  uart_wake_frame #(.OVS(OVS), .DW(DW)) u_frame (
    .clk_i, .rst_ni, .tick_i, .rxd_i,
    .en_i      (rx_en),
    .nine_i    (nine),
    .line_o    (line),
    .busy_o    (busy),
    .done_o    (done),
    .data_o    (frame),
    .stop_ok_o (stop_ok)
  );

  uart_wake_idle #(.OVS(OVS), .DW(DW)) u_idle (
    .clk_i, .rst_ni, .tick_i,
    .line_i (line),
    .busy_i (busy),
    .done_i (done),
    .nine_i (nine),
    .idle_o (idle)
  );

  uart_wake_ctrl #(.DW(DW)) u_ctrl (
    .clk_i, .rst_ni,
    .we_i         (cfg_we_i),
    .w_mod_en_i   (cfg_mod_en_i),
    .w_rx_en_i    (cfg_rx_en_i),
    .w_rwu_i      (cfg_rwu_i),
    .w_wake_sel_i (cfg_wake_sel_i),
    .w_nine_i     (cfg_nine_i),
    .rd_i         (data_rd_i),
    .done_i       (done),
    .frame_i      (frame),
    .stop_ok_i    (stop_ok),
    .idle_i       (idle),
    .data_o       (data_o),
    .full_o       (full_o),
    .ferr_o       (frame_err_o),
    .irq_o        (irq_o),
    .mod_en_o     (mod_en_o),
    .rx_en_o      (rx_en),
    .rwu_o        (rwu_o),
    .wake_sel_o   (wake_sel),
    .nine_o       (nine)
  );

  assign rx_en_o = rx_en;
endmodule

// File: tb/uart_wake_rx_test.sv
`timescale 1ns/1ps
module uart_wake_rx_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i;
  logic       rxd_i = 1'b1;
  logic       cfg_we_i = 1'b0, cfg_mod_en_i = 1'b0, cfg_rx_en_i = 1'b0;
  logic       cfg_rwu_i = 1'b0, cfg_wake_sel_i = 1'b0, cfg_nine_i = 1'b0;
  logic       data_rd_i = 1'b0;
  logic [8:0] data_o;
  logic       full_o, frame_err_o, irq_o, mod_en_o, rx_en_o, rwu_o;

  int vectors = 0;
  int errs = 0;
  bit auto_rd = 1'b1;
  logic [9:0] exp_q[$];
  string      tag_q[$];
  logic [1:0] tdiv = 2'd0;

  always #4 clk = ~clk;
  always @(negedge clk) tdiv <= tdiv + 2'd1;
  assign tick_i = (tdiv == 2'd3);

  uart_wake_rx uut (
    .clk_i(clk), .rst_ni, .tick_i, .rxd_i,
    .cfg_we_i, .cfg_mod_en_i, .cfg_rx_en_i, .cfg_rwu_i, .cfg_wake_sel_i, .cfg_nine_i,
    .data_rd_i, .data_o, .full_o, .frame_err_o, .irq_o, .mod_en_o, .rx_en_o, .rwu_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic slot(input logic v);
    do @(posedge clk); while (!tick_i);
    @(negedge clk);
    rxd_i = v;
  endtask

  task automatic idle_slots(input int n);
    repeat (n) slot(1'b1);
  endtask

  task automatic wr(input logic m, input logic r, input logic w, input logic s, input logic n);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_mod_en_i = m; cfg_rx_en_i = r;
    cfg_rwu_i = w; cfg_wake_sel_i = s; cfg_nine_i = n;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic send(input logic [8:0] d, input int nb, input logic stopv,
                      input int gbit, input bit expect_load, input string tag);
    logic [10:0] bits;
    logic [8:0]  dm;
    bits = '1;
    bits[0] = 1'b0;
    for (int i = 0; i < nb; i++) bits[i+1] = d[i];
    bits[nb+1] = stopv;
    dm = (nb == 8) ? {1'b0, d[7:0]} : d;
    if (expect_load) begin
      exp_q.push_back({~stopv, dm});
      tag_q.push_back(tag);
    end
    for (int b = 0; b < nb + 2; b++)
      for (int k = 0; k < 16; k++)
        slot(bits[b] ^ ((b == gbit) && (k == 8)));
    slot(1'b1);
  endtask

  // monitor: pops the scoreboard on each load, then reads the data
  initial begin
    forever begin
      @(negedge clk);
      if (auto_rd && full_o && rst_ni) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected load", int'(data_o), 0);
        end else begin
          logic [9:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(data_o == e[8:0], {t, " data"}, int'(data_o), int'(e[8:0]));
          chk(frame_err_o == e[9], {t, " frame error"}, int'(frame_err_o), int'(e[9]));
        end
        data_rd_i = 1'b1;
        @(negedge clk);
        data_rd_i = 1'b0;
        @(negedge clk);
        chk(!full_o && !frame_err_o, "R7 flags cleared by read",
            int'({full_o, frame_err_o}), 0);
      end
    end
  end

  initial begin
    #(8 * 150000);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({mod_en_o, rx_en_o, rwu_o, full_o, frame_err_o, irq_o} == 6'b0, "R1 reset state",
        int'({mod_en_o, rx_en_o, rwu_o, full_o, frame_err_o, irq_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(!rx_en_o && !rwu_o, "R1 after release", int'({rx_en_o, rwu_o}), 0);

    // R2: receiver enable locked while module disabled
    wr(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk(rx_en_o == 1'b0, "R2 write ignored", int'(rx_en_o), 0);
    wr(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    chk(rx_en_o == 1'b0 && mod_en_o, "R2 same-write enable ignored", int'(rx_en_o), 0);
    wr(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    chk(rx_en_o == 1'b1, "R2 enable accepted", int'(rx_en_o), 1);
    idle_slots(4);

    send(9'h0A5, 8, 1'b1, -1, 1'b1, "R3");
    idle_slots(4);
    send(9'h03C, 8, 1'b1, -1, 1'b1, "R3");
    idle_slots(4);
    send(9'h05A, 8, 1'b1, 4, 1'b1, "R5 data glitch");
    idle_slots(4);
    send(9'h0C3, 8, 1'b1, 0, 1'b1, "R5 start glitch");
    idle_slots(4);
    send(9'h081, 8, 1'b0, -1, 1'b1, "R6");
    idle_slots(8);

    wr(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    send(9'h1C3, 9, 1'b1, -1, 1'b1, "R4");
    idle_slots(4);
    send(9'h0F0, 9, 1'b1, -1, 1'b1, "R4");
    idle_slots(8);
    wr(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);

    // R12: start pulse too short
    repeat (4) slot(1'b0);
    idle_slots(40);
    chk(full_o == 1'b0 && exp_q.size() == 0, "R12 no load on false start", int'(full_o), 0);

    // R8 and R9 with manual reads
    auto_rd = 1'b0;
    send(9'h06D, 8, 1'b1, -1, 1'b0, "R8");
    idle_slots(4);
    chk(full_o && data_o == 9'h06D, "R8 precondition", int'(data_o), 'h6D);
    wr(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    send(9'h033, 8, 1'b1, -1, 1'b0, "R8");
    idle_slots(4);
    chk(full_o && !frame_err_o && data_o == 9'h06D, "R8 flags and data held",
        int'(data_o), 'h6D);
    chk(rx_en_o == 1'b0, "R8 receiver off", int'(rx_en_o), 0);
    wr(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    chk(!irq_o && full_o, "R9 interrupt masked in standby", int'(irq_o), 0);
    wr(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    chk(irq_o == 1'b1, "R9 interrupt after standby", int'(irq_o), 1);
    @(negedge clk); data_rd_i = 1'b1;
    @(negedge clk); data_rd_i = 1'b0;
    @(negedge clk);
    chk(!full_o && !irq_o, "R7 manual read", int'({full_o, irq_o}), 0);
    auto_rd = 1'b1;

    // R10: idle-line wake
    wr(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    idle_slots(200);
    wr(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    send(9'h011, 8, 1'b1, -1, 1'b0, "R10");
    idle_slots(4);
    chk(!full_o && rwu_o, "R10 standby char dropped", int'({full_o, rwu_o}), 1);
    idle_slots(100);
    chk(rwu_o == 1'b1, "R10 still in standby", int'(rwu_o), 1);
    idle_slots(70);
    chk(rwu_o == 1'b0, "R10 woke on idle", int'(rwu_o), 0);
    send(9'h022, 8, 1'b1, -1, 1'b1, "R10");
    idle_slots(200);

    // R11: address-mark wake
    wr(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    send(9'h012, 8, 1'b1, -1, 1'b0, "R11");
    idle_slots(200);
    chk(rwu_o && !full_o, "R11 non-address dropped, idle ignored",
        int'({rwu_o, full_o}), 2);
    send(9'h085, 8, 1'b1, -1, 1'b1, "R11");
    idle_slots(10);
    chk(rwu_o == 1'b0, "R11 woke on address", int'(rwu_o), 0);

    idle_slots(20);
    chk(exp_q.size() == 0, "R3 all expected loads seen", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule